// File: doc/BRIEF.md
# Parallel Programming Controller for an On-Chip Code Store

This block sits behind the parallel programming pins of a small code memory. While the reset pin is high and the program-store strobe is low, four select pins pick one operation. The operations are writing a code byte, reading a code byte, setting one of three protection bits, erasing the whole array, and reading identification bytes. An external programmer presents an address and a data byte. It then gives one low pulse on the program strobe. The block finishes each write by itself and reports its progress on a ready/busy output and through a polled data bit.

The array is `2**ADDR_W` bytes and is modelled in logic. The high-voltage program enable is a plain logic input. All timings count in clock cycles: `WRITE_CYCLES` is the length of a self-timed write, and `ERASE_CYCLES` is the shortest strobe low time that still erases. This keeps the values short in simulation.

Select pins are gathered in `modeSel[3:0]`. Bit 3 is the first select pin, bit 2 the second, bit 1 the third and bit 0 the fourth, with 1 meaning high.

Top module: `flash_prog_ctrl`

## Requirements
- R1: An operation is decoded only while `pinReset` is 1 and `progStoreN` is 0. At any other time `dataOut` is FFH and strobe pulses have no effect.
- R2: With `modeSel`=0111 and `progEnable`=1, a falling edge on `progPulseN` captures `addr` and `dataIn`. The byte is committed `WRITE_CYCLES` cycles later with no further input. Strobe pulses that arrive while a write is in progress are ignored.
- R3: `readyBusy` goes to 0 in the cycle after an accepted falling edge. It stays at 0 for exactly `WRITE_CYCLES` cycles and then returns to 1.
- R4: While a code write is in progress, a code read of the captured address returns the complement of the new byte's bit 7 on bit 7. Bits 6..0 come from the old stored contents. Once the write ends, the true value is returned.
- R5: With `modeSel`=0011, `dataOut` shows the byte stored at `addr`. A location never written since the last erase reads FFH.
- R6: A code write stores the bitwise AND of the old contents and `dataIn`. Programming only ever clears bits.
- R7: With `modeSel`=1000, a strobe held low for at least `ERASE_CYCLES` cycles and then released sets every byte to FFH and clears all three protection bits. A shorter low time has no effect.
- R8: With `modeSel`=0000, `dataOut` is 1EH at address 030H and 51H at address 031H. At address 032H it is the value of parameter `SIG_VARIANT` (FFH by default). Every other address reads FFH.
- R9: Once protection bit 1 is set, code writes are refused. The array is unchanged and `readyBusy` stays at 1.
- R10: Once protection bits 1 and 2 are both set, code reads return FFH. Identification reads still work.
- R11: With `progEnable` at 0, strobe pulses in write, protection or erase modes do nothing.
- R12: Protection bits 1, 2 and 3 are set by `modeSel` 1111, 1100 and 1010 respectively. Each set is a self-timed write with the same busy timing as R3. Protection bit 3 on its own changes neither code writes nor code reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset; array starts blank |
| pinReset | input | 1 | Reset pin level, must be 1 for programming operations |
| progStoreN | input | 1 | Program-store strobe, must be 0 for programming operations |
| modeSel | input | 4 | Select pins, bit 3 first to bit 0 fourth |
| progPulseN | input | 1 | Active-low program strobe |
| progEnable | input | 1 | Program enable level (logic model of the high-voltage enable) |
| addr | input | ADDR_W | Byte address |
| dataIn | input | 8 | Byte to program |
| dataOut | output | 8 | Read data, polled status or identification byte |
| readyBusy | output | 1 | 1 when ready, 0 while a self-timed write runs |

## Verification
The hardest window to reach is the data-polling one. There, a read of exactly the captured address must happen inside the short busy interval, and the old contents must already be non-blank so that the mixed value differs from both the old and the new byte. The bench switches to read mode in the cycle after the accepted strobe edge and compares against the bench's own copy of the array. Some random writes land on a small, deliberately reused address set, so the AND-accumulation and polling patterns overlap. The erase width is tested at exactly `ERASE_CYCLES` and one cycle short.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    MD_NONE, MD_CODE_WR, MD_CODE_RD, MD_LOCK1,
    MD_LOCK2, MD_LOCK3, MD_ERASE, MD_SIG
  } fpmMode_t;

  typedef struct packed {
    logic latchWrite;
    logic commitWrite;
    logic eraseAll;
    logic readCode;
    logic readSig;
    logic readDenied;
    logic codeBusy;
  } fpmStrobes_t;

  function automatic fpmMode_t decodeMode(input logic [3:0] sel);
    fpmMode_t m;
    case (sel)
      4'b0111: m = MD_CODE_WR;
      4'b0011: m = MD_CODE_RD;
      4'b1111: m = MD_LOCK1;
      4'b1100: m = MD_LOCK2;
      4'b1010: m = MD_LOCK3;
      4'b1000: m = MD_ERASE;
      4'b0000: m = MD_SIG;
      default: m = MD_NONE;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/fpm_ctrl.sv
module fpm_ctrl
  import fpm_pkg::*;
#(
  parameter int WRITE_CYCLES = 8,
  parameter int ERASE_CYCLES = 40
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        pinReset,
  input  logic        progStoreN,
  input  logic [3:0]  modeSel,
  input  logic        progPulseN,
  input  logic        progEnable,
  output fpmStrobes_t strobes,
  output logic        readyBusy
);

  localparam int WCNT_W = $clog2(WRITE_CYCLES + 1);
  localparam int ECNT_W = $clog2(ERASE_CYCLES + 1);

  fpmMode_t mode, pendKind;
  logic pulsePrev, fallEdge, riseEdge;
  logic busyQ;
  logic [WCNT_W-1:0] busyCnt;
  logic eraseActQ;
  logic [ECNT_W-1:0] eraseCnt;
  logic lock1Q, lock2Q, lock3Q;
  logic isLockMode, acceptCode, acceptLock, startErase, commitNow, eraseFire;

  assign mode     = (pinReset && !progStoreN) ? decodeMode(modeSel) : MD_NONE;
  assign fallEdge = pulsePrev && !progPulseN;
  assign riseEdge = !pulsePrev && progPulseN;

  assign isLockMode = (mode == MD_LOCK1) || (mode == MD_LOCK2) || (mode == MD_LOCK3);
  assign acceptCode = fallEdge && !busyQ && !eraseActQ && progEnable
                      && (mode == MD_CODE_WR) && !lock1Q;
  assign acceptLock = fallEdge && !busyQ && !eraseActQ && progEnable && isLockMode;
  assign startErase = fallEdge && !busyQ && !eraseActQ && progEnable && (mode == MD_ERASE);
  assign commitNow  = busyQ && (busyCnt == WCNT_W'(1));
  assign eraseFire  = eraseActQ && riseEdge && (mode == MD_ERASE)
                      && (eraseCnt >= ECNT_W'(ERASE_CYCLES));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pulsePrev <= 1'b1;
    else       pulsePrev <= progPulseN;
  end

  // self-timed write sequencer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ    <= 1'b0;
      busyCnt  <= '0;
      pendKind <= MD_NONE;
    end else if (commitNow) begin
      busyQ <= 1'b0;
    end else if (busyQ) begin
      busyCnt <= busyCnt - WCNT_W'(1);
    end else if (acceptCode || acceptLock) begin
      busyQ    <= 1'b1;
      busyCnt  <= WCNT_W'(WRITE_CYCLES);
      pendKind <= mode;
    end
  end

  // erase pulse width measurement
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      eraseActQ <= 1'b0;
      eraseCnt  <= '0;
    end else if (eraseActQ) begin
      if (mode != MD_ERASE || progPulseN) eraseActQ <= 1'b0;
      else if (eraseCnt < ECNT_W'(ERASE_CYCLES)) eraseCnt <= eraseCnt + ECNT_W'(1);
    end else if (startErase) begin
      eraseActQ <= 1'b1;
      eraseCnt  <= ECNT_W'(1);
    end
  end

  // protection bits
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lock1Q <= 1'b0;
      lock2Q <= 1'b0;
      lock3Q <= 1'b0;
    end else if (eraseFire) begin
      lock1Q <= 1'b0;
      lock2Q <= 1'b0;
      lock3Q <= 1'b0;
    end else if (commitNow) begin
      if (pendKind == MD_LOCK1) lock1Q <= 1'b1;
      if (pendKind == MD_LOCK2) lock2Q <= 1'b1;
      if (pendKind == MD_LOCK3) lock3Q <= 1'b1;
    end
  end

  always_comb begin
    strobes.latchWrite  = acceptCode;
    strobes.commitWrite = commitNow && (pendKind == MD_CODE_WR);
    strobes.eraseAll    = eraseFire;
    strobes.readCode    = (mode == MD_CODE_RD);
    strobes.readSig     = (mode == MD_SIG);
    strobes.readDenied  = lock1Q && lock2Q;
    strobes.codeBusy    = busyQ && (pendKind == MD_CODE_WR);
  end

  assign readyBusy = !busyQ;

  p_busy_after_pulse_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busyQ) |-> !$past(progPulseN));
  p_commit_ready_r2: assert property (@(posedge clk) disable iff (!rstN)
    commitNow |=> readyBusy);
  p_locked_no_busy_r9: assert property (@(posedge clk) disable iff (!rstN)
    (fallEdge && mode == MD_CODE_WR && lock1Q && !busyQ) |=> !busyQ);
  p_no_enable_r11: assert property (@(posedge clk) disable iff (!rstN)
    (fallEdge && !progEnable && !busyQ) |=> !busyQ);
  p_lock3_sticky_r12: assert property (@(posedge clk) disable iff (!rstN)
    (lock3Q && !eraseFire) |=> lock3Q);

endmodule

// File: rtl/fpm_datapath.sv
module fpm_datapath
  import fpm_pkg::*;
#(
  parameter int          ADDR_W      = 12,
  parameter logic [7:0]  SIG_MAKER   = 8'h1E,
  parameter logic [7:0]  SIG_PART    = 8'h51,
  parameter logic [7:0]  SIG_VARIANT = 8'hFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  fpmStrobes_t       strobes,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] dataIn,
  output logic [BYTE_W-1:0] dataOut
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [BYTE_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0]  programmed;
  logic [ADDR_W-1:0] pendAddr;
  logic [BYTE_W-1:0] pendData;
  logic [BYTE_W-1:0] pendWord, readWord, sigByte;
  logic              pollHit;

  assign pendWord = programmed[pendAddr] ? mem[pendAddr] : '1;
  assign readWord = programmed[addr] ? mem[addr] : '1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      programmed <= '0;
      pendAddr   <= '0;
      pendData   <= '1;
    end else begin
      if (strobes.eraseAll)         programmed <= '0;
      else if (strobes.commitWrite) programmed[pendAddr] <= 1'b1;
      if (strobes.latchWrite) begin
        pendAddr <= addr;
        pendData <= dataIn;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.commitWrite) mem[pendAddr] <= pendWord & pendData;
  end

  always_comb begin
    case (addr)
      ADDR_W'(12'h030): sigByte = SIG_MAKER;
      ADDR_W'(12'h031): sigByte = SIG_PART;
      ADDR_W'(12'h032): sigByte = SIG_VARIANT;
      default:          sigByte = '1;
    endcase
  end

  assign pollHit = strobes.codeBusy && (addr == pendAddr);

  always_comb begin
    if (strobes.readSig)
      dataOut = sigByte;
    else if (strobes.readCode && !strobes.readDenied)
      dataOut = pollHit ? {~pendData[BYTE_W-1], readWord[BYTE_W-2:0]} : readWord;
    else
      dataOut = '1;
  end

  p_program_clears_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.commitWrite |=> ((pendWord & ~$past(pendWord)) == '0));
  p_no_relatch_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.codeBusy |-> !strobes.latchWrite);

endmodule

// File: rtl/flash_prog_ctrl.sv
module flash_prog_ctrl
  import fpm_pkg::*;
#(
  parameter int         ADDR_W       = 12,
  parameter int         WRITE_CYCLES = 8,
  parameter int         ERASE_CYCLES = 40,
  parameter logic [7:0] SIG_VARIANT  = 8'hFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pinReset,
  input  logic              progStoreN,
  input  logic [3:0]        modeSel,
  input  logic              progPulseN,
  input  logic              progEnable,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        dataIn,
  output logic [7:0]        dataOut,
  output logic              readyBusy
);

  fpmStrobes_t strobes;

  fpm_ctrl #(
    .WRITE_CYCLES(WRITE_CYCLES),
    .ERASE_CYCLES(ERASE_CYCLES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .pinReset(pinReset), .progStoreN(progStoreN),
    .modeSel(modeSel), .progPulseN(progPulseN), .progEnable(progEnable),
    .strobes(strobes), .readyBusy(readyBusy)
  );

  fpm_datapath #(
    .ADDR_W(ADDR_W),
    .SIG_VARIANT(SIG_VARIANT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .addr(addr), .dataIn(dataIn), .dataOut(dataOut)
  );

endmodule

// File: tb/tb_flash_prog_ctrl.sv
module tb_flash_prog_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 12;
  localparam int WC = 8;
  localparam int EC = 40;

  logic clk = 0, rstN = 0, pinReset = 1, progStoreN = 0;
  logic [3:0] modeSel = 4'b0011;
  logic progPulseN = 1, progEnable = 1;
  logic [AW-1:0] addr = '0;
  logic [7:0] dataIn = '0;
  logic [7:0] dataOut;
  logic readyBusy;

  int nChecks = 0, nFails = 0;
  bit finished = 0;
  logic [7:0] bMem [1<<AW];
  bit bProg [1<<AW];
  bit bL1 = 0, bL2 = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_prog_ctrl #(.ADDR_W(AW), .WRITE_CYCLES(WC), .ERASE_CYCLES(EC)) dut (
    .clk(clk), .rstN(rstN), .pinReset(pinReset), .progStoreN(progStoreN),
    .modeSel(modeSel), .progPulseN(progPulseN), .progEnable(progEnable),
    .addr(addr), .dataIn(dataIn), .dataOut(dataOut), .readyBusy(readyBusy));

  function automatic logic [7:0] expCode(input logic [AW-1:0] a);
    return bProg[a] ? bMem[a] : 8'hFF;
  endfunction

  function automatic logic [7:0] expRead(input logic [AW-1:0] a);
    return (bL1 && bL2) ? 8'hFF : expCode(a);
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic readCheck(input logic [AW-1:0] a, input string req);
    @(negedge clk);
    modeSel = 4'b0011; addr = a; #1;
    check(req, dataOut, expRead(a));
  endtask

  // one-cycle strobe in the given mode; returns after the accepting edge
  task automatic strobe(input logic [3:0] m, input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    modeSel = m; addr = a; dataIn = d; progPulseN = 0;
    @(negedge clk);
    progPulseN = 1;
  endtask

  task automatic codeWrite(input logic [AW-1:0] a, input logic [7:0] d, input bit expAccept);
    logic [7:0] old;
    old = expCode(a);
    strobe(4'b0111, a, d);
    check(expAccept ? "R3 busy low" : "R9 no busy", {7'b0, readyBusy}, {7'b0, !expAccept});
    if (expAccept) begin
      modeSel = 4'b0011; addr = a; #1;
      if (!(bL1 && bL2)) check("R4 poll", dataOut, {~d[7], old[6:0]});
      repeat (WC) @(negedge clk);
      check("R3 ready again", {7'b0, readyBusy}, 8'h01);
      bMem[a] = old & d; bProg[a] = 1;
    end else begin
      repeat (WC + 1) @(negedge clk);
    end
  endtask

  task automatic lockWrite(input logic [3:0] m);
    strobe(m, '0, '0);
    check("R12 lock busy", {7'b0, readyBusy}, 8'h00);
    repeat (WC) @(negedge clk);
    check("R12 lock ready", {7'b0, readyBusy}, 8'h01);
    if (m == 4'b1111) bL1 = 1;
    if (m == 4'b1100) bL2 = 1;
  endtask

  task automatic erase(input int lowCycles);
    @(negedge clk);
    modeSel = 4'b1000; progPulseN = 0;
    repeat (lowCycles) @(negedge clk);
    progPulseN = 1;
    repeat (2) @(negedge clk);
    if (lowCycles >= EC) begin
      foreach (bProg[i]) bProg[i] = 0;
      bL1 = 0; bL2 = 0;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nFails++; nChecks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    void'($urandom(32'd1234));
    foreach (bProg[i]) bProg[i] = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    #1;
    check("R3 reset ready", {7'b0, readyBusy}, 8'h01);
    readCheck(12'h005, "R5 blank read");

    // R8 identification bytes
    @(negedge clk); modeSel = 4'b0000; addr = 12'h030; #1; check("R8 sig 030", dataOut, 8'h1E);
    addr = 12'h031; #1; check("R8 sig 031", dataOut, 8'h51);
    addr = 12'h032; #1; check("R8 sig 032", dataOut, 8'hFF);
    addr = 12'h033; #1; check("R8 sig other", dataOut, 8'hFF);

    // R2/R5 basic write then R6 AND accumulation and R4 polling on non-blank
    codeWrite(12'h010, 8'h3C, 1);
    readCheck(12'h010, "R5 read back");
    codeWrite(12'h010, 8'hF5, 1);
    readCheck(12'h010, "R6 bits only clear");
    codeWrite(12'h020, 8'h7F, 1);
    readCheck(12'h020, "R4 true after busy");

    // R2 pulse during busy ignored
    strobe(4'b0111, 12'h040, 8'hA5);
    strobe(4'b0111, 12'h041, 8'h00);
    repeat (WC + 1) @(negedge clk);
    bMem[12'h040] = 8'hA5; bProg[12'h040] = 1;
    readCheck(12'h041, "R2 busy pulse ignored");
    readCheck(12'h040, "R2 first write kept");

    // R1 gating
    @(negedge clk); progStoreN = 1; modeSel = 4'b0011; addr = 12'h040; #1;
    check("R1 strobe high FF", dataOut, 8'hFF);
    progStoreN = 0; pinReset = 0;
    strobe(4'b0111, 12'h050, 8'h00);
    check("R1 no busy", {7'b0, readyBusy}, 8'h01);
    pinReset = 1;
    readCheck(12'h050, "R1 no write");

    // R11 enable low
    progEnable = 0;
    strobe(4'b0111, 12'h051, 8'h00);
    check("R11 no busy", {7'b0, readyBusy}, 8'h01);
    erase(EC + 2);
    progEnable = 1;
    bMem[12'h040] = 8'hA5; bProg[12'h040] = 1;  // erase ignored: restore model
    bProg[12'h010] = 1; bProg[12'h020] = 1;
    readCheck(12'h051, "R11 no write");
    readCheck(12'h040, "R11 no erase");

    // R7 short erase aborted, exact width erases
    erase(EC - 1);
    bProg[12'h040] = 1; bProg[12'h010] = 1; bProg[12'h020] = 1;
    readCheck(12'h040, "R7 short erase no effect");
    erase(EC);
    readCheck(12'h040, "R7 erased FF");
    readCheck(12'h010, "R7 erased FF b");

    // random phase on a small reused address set
    for (int i = 0; i < 40; i++) begin
      logic [AW-1:0] a;
      a = AW'(12'h100 + ($urandom % 6));
      if ($urandom % 3 != 0) codeWrite(a, 8'($urandom), 1);
      else readCheck(a, "R5 random read");
    end

    // protection bits
    lockWrite(4'b1010);
    codeWrite(12'h200, 8'h12, 1);
    readCheck(12'h200, "R12 lock3 alone no effect");
    lockWrite(4'b1111);
    codeWrite(12'h200, 8'h00, 0);
    readCheck(12'h200, "R9 write refused");
    lockWrite(4'b1100);
    readCheck(12'h200, "R10 read refused");
    @(negedge clk); modeSel = 4'b0000; addr = 12'h031; #1;
    check("R10 sig still readable", dataOut, 8'h51);
    erase(EC + 5);
    readCheck(12'h200, "R7 erase clears locks");
    codeWrite(12'h200, 8'h5A, 1);
    readCheck(12'h200, "R7 writable after erase");

    rd = dataOut;
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule